// File: doc/BRIEF.md
# Serial EEPROM Device-Select Decoder

This block watches a two-wire serial bus (clock and data lines, already brought on chip as plain levels) and interprets the first byte that follows each Start condition. Bits are taken on the rising edge of the clock, most significant first. The byte has three fields: the upper nibble is a device-type code, the next three bits are a chip-enable field, and the lowest bit is the read/write flag. If the byte addresses this device, the block pulls the data line low during the ninth clock to acknowledge. It then reports which command was requested.

Two device types are recognised. The first is the storage-array type, which is accepted when the chip-enable field equals the three strap pins. The second is the protection-control type, which carries three commands and their read-back queries. Two of these commands ignore the strap match. They require a high-voltage level on the lowest strap pin and fixed levels on the other two. The third needs an ordinary strap match with no high voltage present. While the power-on-reset flag is set, the block ignores the bus completely.

Top module: `eesel_select_decoder`

## Requirements
- R1: After a Start, the block takes eight bits on successive rising SCL edges, most significant first. Bits [7:4] are the type, bits [3:1] the chip-enable field and bit [0] the read/write flag (1 = read, 0 = write). The flag appears on `cmd_rw` together with the command.
- R2: Type 4'b1010 is accepted only when bits [3:1] equal `ce_pins` (bit 2 = A2, bit 0 = A0). The command code is 1 for a write and 2 for a read.
- R3: Type 4'b0110 with field 3'b001 is accepted when `a0_hv`=1, `ce_pins[2]`=0 and `ce_pins[1]`=0. The code is 3 for a write (set protection) and 6 for a read (query).
- R4: Type 4'b0110 with field 3'b011 is accepted when `a0_hv`=1, `ce_pins[2]`=0 and `ce_pins[1]`=1. The code is 4 for a write (clear protection) and 7 for a read (query).
- R5: Type 4'b0110 with the field equal to `ce_pins` is accepted only when `a0_hv`=0. The code is 5 for a write (permanent protection) and 8 for a read (query). While `a0_hv`=1, type 4'b0110 is accepted only in the R3 and R4 forms.
- R6: On acceptance, `sda_pull` rises after the SCL fall that ends bit 8 and falls after the SCL fall that ends the ninth clock. At the same moment it rises, `selected` rises.
- R7: A byte that is not accepted (any other type, or a field that does not match) gets no acknowledge and no `cmd_valid`. All further clocks are ignored until the next Start.
- R8: `cmd_valid` is a single-cycle pulse at the end of the acknowledge clock. `cmd_code` and `cmd_rw` hold their values until the next Start. `selected` stays high until the next Start or Stop.
- R9: While `por_active` is 1, no traffic is decoded, `sda_pull` stays 0 and `cmd_valid` stays 0.
- R10: A Start inside the byte restarts bit counting from the first bit. A Stop inside the byte abandons decoding until the next Start.
- R11: After reset, `sda_pull`, `cmd_valid`, `selected` and `cmd_rw` are 0 and `cmd_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock level |
| sda_in | input | 1 | Serial data level as seen on the wire |
| ce_pins | input | 3 | Strap pin levels, bit 2 = A2 … bit 0 = A0 |
| a0_hv | input | 1 | High-voltage condition present on the A0 strap |
| por_active | input | 1 | Power-on-reset flag; silences the block |
| sda_pull | output | 1 | 1 = pull data line low (acknowledge) |
| cmd_valid | output | 1 | One-cycle pulse when a command is decoded |
| cmd_code | output | 4 | Decoded command code (R2–R5) |
| cmd_rw | output | 1 | Read/write bit of the accepted byte |
| selected | output | 1 | Device addressed in the current transfer |

## Verification
The embedded assertions check several properties on every cycle. The acknowledge only ever rises after the decoder has reported a match. Power-on reset silences both the acknowledge and the valid pulse. The valid pulse lasts one cycle and carries a non-empty code while the device is selected. A Start drops both the acknowledge and the selection. The bit counter never goes past the byte width. Only the bench's bus scenarios can show the full decode table under the strap and high-voltage combinations. The same holds for the exact acknowledge window seen on the wire, the standby after a rejected byte, and recovery from a Start or Stop in the middle of a byte.

// File: rtl/eesel_pkg.sv
// Shared constants and types for the device-select decoder.
package eesel_pkg;
    localparam int BYTE_W = 8;
    localparam int TYPE_W = 4;
    localparam int CE_W   = 3;

    localparam logic [TYPE_W-1:0] TYPE_MEM  = 4'b1010;
    localparam logic [TYPE_W-1:0] TYPE_PROT = 4'b0110;
    localparam logic [CE_W-1:0]   FLD_SET   = 3'b001;
    localparam logic [CE_W-1:0]   FLD_CLR   = 3'b011;

    typedef enum logic [3:0] {
        CMD_NONE    = 4'd0,
        CMD_MEM_WR  = 4'd1,
        CMD_MEM_RD  = 4'd2,
        CMD_SET_WP  = 4'd3,
        CMD_CLR_WP  = 4'd4,
        CMD_PERM_WP = 4'd5,
        CMD_RD_SET  = 4'd6,
        CMD_RD_CLR  = 4'd7,
        CMD_RD_PERM = 4'd8
    } eesel_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_STANDBY
    } eesel_state_e;
endpackage

// File: rtl/eesel_sync.sv
// Bus-line synchroniser and condition detector.
// Brings SCL and SDA into the clk domain through STAGES flops each.
// Produces one-cycle strobes for SCL edges and for Start/Stop conditions.
// Assumes clk is several times faster than SCL. Idle bus level is high.
module eesel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] lvl;
    logic [NSIG-1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar i = 0; i < NSIG; i++) begin : g_chain
        logic [STAGES:0] q;
        // Shift chain: stages for metastability, plus one for the previous value.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-1:0], raw[i]};
        end
        assign lvl[i]  = q[STAGES-1];
        assign prev[i] = q[STAGES];
    end

    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prev[0];
    assign scl_fall  = ~lvl[0] & prev[0];
    assign start_det = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/eesel_shift.sv
// Serial-to-parallel collector for the select byte.
// On each strobe it shifts one bit in at the LSB end, so the first bit ends up as the MSB.
// It stops after BITS bits and raises full. A clear empties it.
module eesel_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            strobe,
    input  logic            bit_in,
    output logic [BITS-1:0] data,
    output logic            full
);
    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] cnt;

    assign full = (cnt == CNT_W'(BITS));

    // Bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            data <= '0;
        end else if (strobe && !full) begin
            cnt  <= cnt + 1'b1;
            data <= {data[BITS-2:0], bit_in};
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BITS)); // R1
endmodule

// File: rtl/eesel_classify.sv
// Combinational classifier for a completed select byte.
// Maps the type, field and RW bit, together with the strap pins and the
// high-voltage flag, to a command code. Reports whether the byte is accepted.
module eesel_classify
    import eesel_pkg::*;
(
    input  logic [BYTE_W-1:0] sel_byte,
    input  logic [CE_W-1:0]   ce_pins,
    input  logic              a0_hv,
    output eesel_cmd_e        cmd,
    output logic              match
);
    logic [TYPE_W-1:0] typ;
    logic [CE_W-1:0]   fld;
    logic              rd;

    assign typ = sel_byte[BYTE_W-1 -: TYPE_W];
    assign fld = sel_byte[CE_W:1];
    assign rd  = sel_byte[0];

    // Decode priority: storage array, then high-voltage commands, then strap-matched protection.
    always_comb begin
        cmd = CMD_NONE;
        if (typ == TYPE_MEM) begin
            if (fld == ce_pins) cmd = rd ? CMD_MEM_RD : CMD_MEM_WR;
        end else if (typ == TYPE_PROT) begin
            if (a0_hv) begin
                if (fld == FLD_SET && !ce_pins[2] && !ce_pins[1])
                    cmd = rd ? CMD_RD_SET : CMD_SET_WP;
                else if (fld == FLD_CLR && !ce_pins[2] && ce_pins[1])
                    cmd = rd ? CMD_RD_CLR : CMD_CLR_WP;
            end else if (fld == ce_pins) begin
                cmd = rd ? CMD_RD_PERM : CMD_PERM_WP;
            end
        end
    end

    assign match = (cmd != CMD_NONE);
endmodule

// File: rtl/eesel_select_decoder.sv
// Top level of the device-select decoder.
// Sequences the synchroniser, the byte collector and the classifier.
// Drives the acknowledge during the ninth clock and publishes the command.
// Assumes clk is at least 8x the SCL rate. sda_in is the wired level,
// including this block's own pull.
module eesel_select_decoder
    import eesel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] ce_pins,
    input  logic       a0_hv,
    input  logic       por_active,
    output logic       sda_pull,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       cmd_rw,
    output logic       selected
);
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] sel_byte;
    logic              byte_full;
    eesel_cmd_e        dec_cmd;
    logic              dec_match;
    eesel_state_e      state;
    eesel_cmd_e        code_q, pend_code;
    logic              pend_rw;

    eesel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eesel_shift #(.BITS(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_det || por_active),
        .strobe (scl_rise && state == ST_SHIFT && !por_active),
        .bit_in (sda_lvl),
        .data   (sel_byte),
        .full   (byte_full)
    );

    eesel_classify u_cls (
        .sel_byte (sel_byte),
        .ce_pins  (ce_pins),
        .a0_hv    (a0_hv),
        .cmd      (dec_cmd),
        .match    (dec_match)
    );

    // Transfer sequencer: bit phase, acknowledge, hold and standby.
    always_ff @(posedge clk) begin
        if (!rst_n || por_active) begin
            state     <= ST_IDLE;
            sda_pull  <= 1'b0;
            cmd_valid <= 1'b0;
            selected  <= 1'b0;
            code_q    <= CMD_NONE;
            pend_code <= CMD_NONE;
            pend_rw   <= 1'b0;
            cmd_rw    <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_det) begin
                state    <= ST_SHIFT;
                sda_pull <= 1'b0;
                selected <= 1'b0;
                code_q   <= CMD_NONE;
                cmd_rw   <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                selected <= 1'b0;
            end else begin
                unique case (state)
                    ST_SHIFT: begin
                        if (byte_full && scl_fall) begin
                            if (dec_match) begin
                                state     <= ST_ACK;
                                sda_pull  <= 1'b1;
                                selected  <= 1'b1;
                                pend_code <= dec_cmd;
                                pend_rw   <= sel_byte[0];
                            end else begin
                                state <= ST_STANDBY;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state     <= ST_HOLD;
                            sda_pull  <= 1'b0;
                            cmd_valid <= 1'b1;
                            code_q    <= pend_code;
                            cmd_rw    <= pend_rw;
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    assign cmd_code = code_q;

    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(dec_match)); // R6
    AST_ACK_IMPLIES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> selected); // R6
    AST_POR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        por_active |=> (!sda_pull && !cmd_valid)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R8
    AST_VALID_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code != 4'd0 && selected)); // R8
    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_pull && !selected)); // R10
endmodule

// File: tb/tb_eesel_select_decoder.sv
module tb_eesel_select_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] ce_pins = 3'b000;
    logic       a0_hv = 1'b0;
    logic       por_active = 1'b0;
    logic       sda_pull, cmd_valid, cmd_rw, selected;
    logic [3:0] cmd_code;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int exp_code_q[$];
    int exp_rw_q[$];
    string exp_req_q[$];

    assign sda_line = sda_drv & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    eesel_select_decoder dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .ce_pins(ce_pins), .a0_hv(a0_hv), .por_active(por_active),
        .sda_pull(sda_pull), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_rw(cmd_rw), .selected(selected)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_clk(Q);
        scl = 1'b1;     wait_clk(Q);
        sda_drv = 1'b0; wait_clk(Q);
        scl = 1'b0;     wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(Q);
        scl = 1'b1;     wait_clk(Q);
        sda_drv = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bit(input bit b);
        sda_drv = b;    wait_clk(Q);
        scl = 1'b1;     wait_clk(2*Q);
        scl = 1'b0;     wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Ninth clock: release data, sample the wire in mid-high phase.
    task automatic ack_clock(output bit acked, output bit sel);
        sda_drv = 1'b1; wait_clk(Q);
        scl = 1'b1;     wait_clk(Q);
        acked = !sda_line;
        sel = selected;
        wait_clk(Q);
        scl = 1'b0;     wait_clk(Q);
    endtask

    // Driver: one byte plus acknowledge clock; expected items go to the scoreboard.
    task automatic run_byte(input logic [7:0] b, input bit exp_ack, input int exp_code, input string req);
        bit acked, sel;
        if (exp_ack) begin
            exp_code_q.push_back(exp_code);
            exp_rw_q.push_back(int'(b[0]));
            exp_req_q.push_back(req);
        end
        send_byte(b);
        ack_clock(acked, sel);
        wait_clk(Q);
        check(acked == exp_ack, {req, " ack"}, acked, exp_ack);
        check(sel == exp_ack, {req, " selected"}, sel, exp_ack);
        if (exp_ack) check(cmd_code == exp_code, {req, " code hold R8"}, cmd_code, exp_code);
    endtask

    task automatic frame(input logic [7:0] b, input bit exp_ack, input int exp_code, input string req);
        bus_start();
        run_byte(b, exp_ack, exp_code, req);
        bus_stop();
        wait_clk(Q);
        check(selected == 1'b0, {req, " selected after stop R8"}, selected, 0);
        check(sda_pull == 1'b0, {req, " released R6"}, sda_pull, 0);
    endtask

    // Monitor: pops and compares expected command items on each valid pulse.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_code_q.size() == 0) begin
                check(1'b0, "R7 unexpected cmd_valid", cmd_code, 0);
            end else begin
                int ec, er;
                string rq;
                ec = exp_code_q.pop_front();
                er = exp_rw_q.pop_front();
                rq = exp_req_q.pop_front();
                check(cmd_code == ec, {rq, " cmd_code"}, cmd_code, ec);
                check(cmd_rw == er, {rq, " cmd_rw R1"}, cmd_rw, er);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        bit acked, sel;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R11 reset state
        check(sda_pull == 0, "R11 sda_pull", sda_pull, 0);
        check(cmd_valid == 0, "R11 cmd_valid", cmd_valid, 0);
        check(selected == 0, "R11 selected", selected, 0);
        check(cmd_code == 0, "R11 cmd_code", cmd_code, 0);
        check(cmd_rw == 0, "R11 cmd_rw", cmd_rw, 0);

        // R2 storage array, straps 101
        ce_pins = 3'b101;
        frame(8'b1010_101_0, 1, 1, "R2 mem write");
        frame(8'b1010_101_1, 1, 2, "R2 mem read");
        frame(8'b1010_100_0, 0, 0, "R2 strap mismatch");
        frame(8'b1111_101_0, 0, 0, "R7 unknown type");

        // R3 set protection under high voltage
        ce_pins = 3'b001; a0_hv = 1'b1;
        frame(8'b0110_001_0, 1, 3, "R3 set");
        frame(8'b0110_001_1, 1, 6, "R3 set query");
        ce_pins = 3'b011;
        frame(8'b0110_001_0, 0, 0, "R3 A1 high rejects set");

        // R4 clear protection
        frame(8'b0110_011_0, 1, 4, "R4 clear");
        frame(8'b0110_011_1, 1, 7, "R4 clear query");
        ce_pins = 3'b111;
        frame(8'b0110_011_0, 0, 0, "R4 A2 high rejects clear");

        // R5 permanent protection
        ce_pins = 3'b110; a0_hv = 1'b0;
        frame(8'b0110_110_0, 1, 5, "R5 permanent");
        frame(8'b0110_110_1, 1, 8, "R5 permanent query");
        ce_pins = 3'b001;
        frame(8'b0110_001_0, 1, 5, "R5 field 001 without HV");
        ce_pins = 3'b101; a0_hv = 1'b1;
        frame(8'b0110_101_0, 0, 0, "R5 HV blocks strap match");
        a0_hv = 1'b0;

        // R7 standby after a rejected byte
        bus_start();
        run_byte(8'b1010_000_0, 0, 0, "R7 rejected");
        run_byte(8'b1010_101_0, 0, 0, "R7 ignored until Start");
        bus_stop();
        wait_clk(Q);

        // R9 power-on reset silences
        por_active = 1'b1;
        frame(8'b1010_101_0, 0, 0, "R9 por");
        por_active = 1'b0;
        wait_clk(Q);

        // R10 Start in mid byte restarts
        bus_start();
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        frame(8'b1010_101_1, 1, 2, "R10 repeated start");

        // R10 Stop in mid byte aborts
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        bus_stop();
        scl = 1'b0; wait_clk(Q);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        ack_clock(acked, sel);
        wait_clk(Q);
        check(acked == 0, "R10 stop abort ack", acked, 0);
        check(sel == 0, "R10 stop abort selected", sel, 0);
        scl = 1'b1; wait_clk(Q);

        wait_clk(4*Q);
        check(exp_code_q.size() == 0, "R8 pending commands", exp_code_q.size(), 0);
        summary();
        $finish;
    end
endmodule